// File: doc/BRIEF.md
# Serial-Bus Output-Enable Configuration Receiver

This block is the write-only configuration port of a multi-output clock buffer. It watches the two open-drain lines of a two-wire serial bus, SCL and SDA, and samples both with a much faster system clock. From the sampled lines it finds start and stop conditions and takes in bytes most significant bit first. After each byte it acknowledges by asserting a pull-low enable for the SDA pad. It never drives SDA high.

A host programs the block with one fixed block-write frame of ten bytes. The first byte is the device address. The second is a command code and the third is a byte count, and neither carries any meaning here. Seven data bytes follow. Data bytes 0 and 1 set a 13-bit output-enable vector, which gates the buffered clock outputs. Data byte 2 is stored but drives no output. The last four data bytes are acknowledged and then dropped. The block has no read path.

Top module: `cfg_slave_rx`

## Requirements
- R1: Only the address byte 8'hD2 (binary 11010010) is accepted. For any other address no byte of the frame is acknowledged and `clk_en_o` keeps its value.
- R2: In an accepted frame, bit i of data byte 0 (the fourth byte on the bus) sets `clk_en_o[i]` for i = 0..7. Bit j of data byte 1 (the fifth byte) sets `clk_en_o[8+j]` for j = 0..4. A 1 enables an output and a 0 disables it.
- R3: The command code byte and the byte count byte are acknowledged whatever their value, and they have no effect on `clk_en_o`.
- R4: Bits 7..5 of data byte 1, all of data byte 2, and data bytes 3 to 6 have no effect on `clk_en_o`. Data bytes 3 to 6 are still acknowledged. Any byte after the tenth is not acknowledged.
- R5: Every byte is shifted in most significant bit first. The first bit received is bit 7.
- R6: To acknowledge a byte, `sda_pull_o` rises after the SCL falling edge that ends the eighth bit. It stays high through the ninth SCL high phase and returns to 0 after the ninth SCL falling edge.
- R7: An SDA fall while SCL is high is a start condition, and an SDA rise while SCL is high is a stop condition. A start condition received in the middle of a frame restarts it at the address byte.
- R8: Each data byte takes effect on `clk_en_o` as soon as its acknowledge ends. A frame cut short by a stop condition keeps the data bytes already acknowledged.
- R9: After reset `clk_en_o` is all ones (every output enabled) and `sda_pull_o` is 0.
- R10: After an address mismatch the block stays silent (`sda_pull_o` stays 0) until the next start condition.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System sampling clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_pull_o | output | 1 | Pull-low enable for the SDA pad, 1 while acknowledging |
| clk_en_o | output | 13 | Output-enable vector for the buffered clocks, 1 = enabled |

## Verification
Each line change passes through two synchronizer flops and one edge register before the state machine reacts to it. The acknowledge therefore rises about four system clocks after the SCL fall that ends bit eight, and a data byte reaches `clk_en_o` about four clocks after the SCL fall that ends its acknowledge. The bench holds every SCL phase for eight system clocks. It reads the acknowledge in the middle of the ninth high phase and checks that the pull is released in the middle of the next bit's high phase. It reads `clk_en_o` at least ten clocks after the acknowledge or stop it depends on. Every read happens on the falling system-clock edge, so none of them lands on a cycle where the value is still changing.

// File: rtl/cfgrx_pkg.sv
package cfgrx_pkg;
   typedef enum logic [1:0] {
      RX_IDLE  = 2'd0,
      RX_SHIFT = 2'd1,
      RX_ACK   = 2'd2,
      RX_HOLD  = 2'd3
   } rx_state_e;

   localparam int unsigned BYTE_W = 8;
endpackage

// File: rtl/cfgrx_sync.sv
module cfgrx_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_q,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   localparam int unsigned LINES = 2;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("cfgrx_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0][LINES-1:0] pipe;
   logic [LINES-1:0]             prev;
   logic [LINES-1:0]             cur;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pipe <= '1;
         prev <= '1;
      end else begin
         pipe <= {pipe[STAGES-2:0], {scl_i, sda_i}};
         prev <= pipe[STAGES-1];
      end
   end

   assign cur       = pipe[STAGES-1];
   assign sda_q     = cur[0];
   assign scl_rise  =  cur[1] && !prev[1];
   assign scl_fall  = !cur[1] &&  prev[1];
   assign start_det =  cur[1] &&  prev[1] &&  prev[0] && !cur[0];
   assign stop_det  =  cur[1] &&  prev[1] && !prev[0] &&  cur[0];
endmodule

// File: rtl/cfgrx_frame.sv
module cfgrx_frame
   import cfgrx_pkg::*;
#(
   parameter logic [7:0]  DEV_ADDR    = 8'hD2,
   parameter int unsigned FRAME_BYTES = 10,
   parameter int unsigned HDR_BYTES   = 3,
   parameter int unsigned REG_BYTES   = 3,
   localparam int unsigned CNTW = $clog2(FRAME_BYTES + 1),
   localparam int unsigned IDXW = (REG_BYTES > 1) ? $clog2(REG_BYTES) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sda_q,
   input  logic               scl_rise,
   input  logic               scl_fall,
   input  logic               start_det,
   input  logic               stop_det,
   output logic               sda_pull,
   output logic               wr_en,
   output logic [IDXW-1:0]    wr_idx,
   output logic [BYTE_W-1:0]  wr_data
);
   generate
      if (HDR_BYTES + REG_BYTES > FRAME_BYTES) begin : g_bad_frame
         $error("cfgrx_frame: register bytes do not fit in the frame");
      end
      if (IDXW > CNTW) begin : g_bad_idx
         $error("cfgrx_frame: index wider than byte counter");
      end
   endgenerate

   rx_state_e         state;
   logic [3:0]        bit_cnt;
   logic [CNTW-1:0]   byte_cnt;
   logic [BYTE_W-1:0] shreg;
   logic              in_regs;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= RX_IDLE;
         bit_cnt  <= '0;
         byte_cnt <= '0;
         shreg    <= '0;
         sda_pull <= 1'b0;
      end else if (start_det) begin
         state    <= RX_SHIFT;
         bit_cnt  <= '0;
         byte_cnt <= '0;
         sda_pull <= 1'b0;
      end else if (stop_det) begin
         state    <= RX_IDLE;
         sda_pull <= 1'b0;
      end else begin
         case (state)
            RX_SHIFT: begin
               if (scl_rise && bit_cnt < 4'd8) begin
                  shreg   <= {shreg[BYTE_W-2:0], sda_q};
                  bit_cnt <= bit_cnt + 4'd1;
               end else if (scl_fall && bit_cnt == 4'd8) begin
                  if (byte_cnt == '0 && shreg != DEV_ADDR) begin
                     state <= RX_HOLD;
                  end else begin
                     sda_pull <= 1'b1;
                     state    <= RX_ACK;
                  end
               end
            end
            RX_ACK: begin
               if (scl_fall) begin
                  sda_pull <= 1'b0;
                  bit_cnt  <= '0;
                  byte_cnt <= byte_cnt + CNTW'(1);
                  state    <= (byte_cnt == CNTW'(FRAME_BYTES - 1)) ? RX_HOLD : RX_SHIFT;
               end
            end
            default: ;
         endcase
      end
   end

   assign in_regs = (byte_cnt >= CNTW'(HDR_BYTES)) &&
                    (byte_cnt <  CNTW'(HDR_BYTES + REG_BYTES));
   assign wr_en   = (state == RX_ACK) && scl_fall && !start_det && !stop_det && in_regs;
   assign wr_idx  = IDXW'(byte_cnt - CNTW'(HDR_BYTES));
   assign wr_data = shreg;

   // R6
   ack_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_pull) |-> $past(scl_fall));

   // R6
   ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sda_pull) |-> $past(scl_fall || start_det || stop_det));

   // R5
   bit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bit_cnt <= 4'd8);

   // R8
   wr_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (int'(wr_idx) < REG_BYTES));
endmodule

// File: rtl/cfgrx_enreg.sv
module cfgrx_enreg #(
   parameter int unsigned REG_BYTES = 3,
   parameter int unsigned N_OUT     = 13,
   localparam int unsigned IDXW = (REG_BYTES > 1) ? $clog2(REG_BYTES) : 1,
   localparam int unsigned REGW = REG_BYTES * 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDXW-1:0]  wr_idx,
   input  logic [7:0]       wr_data,
   output logic [N_OUT-1:0] en_o
);
   function automatic logic [REGW-1:0] reset_image();
      logic [REGW-1:0] r;
      for (int i = 0; i < REGW; i++) r[i] = (i < N_OUT);
      return r;
   endfunction

   localparam logic [REGW-1:0] RST_VAL = reset_image();

   generate
      if (N_OUT > REGW) begin : g_bad_width
         $error("cfgrx_enreg: more outputs than register bits");
      end
   endgenerate

   logic [REGW-1:0] q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= RST_VAL;
      else if (wr_en) q[int'(wr_idx)*8 +: 8] <= wr_data;
   end

   generate
      for (genvar i = 0; i < N_OUT; i++) begin : g_map
         assign en_o[i] = q[i];
      end
   endgenerate
endmodule

// File: rtl/cfg_slave_rx.sv
module cfg_slave_rx #(
   parameter logic [7:0]  DEV_ADDR    = 8'hD2,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned FRAME_BYTES = 10,
   parameter int unsigned HDR_BYTES   = 3,
   parameter int unsigned REG_BYTES   = 3,
   parameter int unsigned N_OUT       = 13
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scl_i,
   input  logic             sda_i,
   output logic             sda_pull_o,
   output logic [N_OUT-1:0] clk_en_o
);
   localparam int unsigned IDXW = (REG_BYTES > 1) ? $clog2(REG_BYTES) : 1;

   logic            sda_q, scl_rise, scl_fall, start_det, stop_det;
   logic            wr_en;
   logic [IDXW-1:0] wr_idx;
   logic [7:0]      wr_data;

   cfgrx_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .sda_q(sda_q), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det)
   );

   cfgrx_frame #(
      .DEV_ADDR(DEV_ADDR), .FRAME_BYTES(FRAME_BYTES),
      .HDR_BYTES(HDR_BYTES), .REG_BYTES(REG_BYTES)
   ) i_frame (
      .clk(clk), .rst_n(rst_n), .sda_q(sda_q), .scl_rise(scl_rise),
      .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
      .sda_pull(sda_pull_o), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
   );

   cfgrx_enreg #(.REG_BYTES(REG_BYTES), .N_OUT(N_OUT)) i_enreg (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
      .wr_data(wr_data), .en_o(clk_en_o)
   );

   // R8
   en_on_scl_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(clk_en_o) |-> $past(scl_fall));

   // R6
   pull_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $changed(sda_pull_o) |-> !$past(scl_rise));
endmodule

// File: tb/test_cfg_slave_rx.sv
module test_cfg_slave_rx;
   localparam int HALF = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        scl_drv = 1'b1;
   logic        sda_drv = 1'b1;
   logic        sda_line;
   logic        sda_pull_o;
   logic [12:0] clk_en_o;
   logic [12:0] en_model = 13'h1FFF;
   int          n_chk = 0;
   int          n_bad = 0;
   bit          done = 1'b0;

   always #2 clk = ~clk;

   assign sda_line = sda_drv & ~sda_pull_o;

   cfg_slave_rx i_cfg_slave_rx (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_drv), .sda_i(sda_line),
      .sda_pull_o(sda_pull_o), .clk_en_o(clk_en_o)
   );

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic bus_start();
      sda_drv = 1'b1; wait_clk(HALF);
      scl_drv = 1'b1; wait_clk(HALF);
      sda_drv = 1'b0; wait_clk(HALF);
      scl_drv = 1'b0; wait_clk(HALF);
   endtask

   task automatic bus_stop();
      sda_drv = 1'b0; wait_clk(HALF);
      scl_drv = 1'b1; wait_clk(HALF);
      sda_drv = 1'b1; wait_clk(HALF);
   endtask

   task automatic send_byte(input logic [7:0] b, output bit acked);
      for (int i = 7; i >= 0; i--) begin
         sda_drv = b[i]; wait_clk(HALF);
         scl_drv = 1'b1; wait_clk(HALF / 2);
         if (i == 7) check(sda_pull_o == 1'b0, "R6 release", 32'(sda_pull_o), 0);
         wait_clk(HALF / 2);
         scl_drv = 1'b0;
      end
      sda_drv = 1'b1; wait_clk(HALF);
      scl_drv = 1'b1; wait_clk(HALF / 2);
      acked = (sda_line == 1'b0);
      wait_clk(HALF / 2);
      scl_drv = 1'b0;
   endtask

   function automatic logic [12:0] enable_of(input logic [7:0] d0, input logic [7:0] d1);
      return {d1[4:0], d0};
   endfunction

   task automatic run_frame(input logic [7:0] addr, input logic [7:0] d0, input logic [7:0] d1,
                            input int extra, input string req);
      logic [7:0] fb [0:15];
      bit ok_addr, ack;
      ok_addr = (addr == 8'hD2);
      fb[0] = addr; fb[1] = 8'($urandom); fb[2] = 8'($urandom);
      fb[3] = d0; fb[4] = d1;
      for (int k = 5; k < 16; k++) fb[k] = 8'($urandom);
      bus_start();
      for (int j = 0; j < 10 + extra; j++) begin
         send_byte(fb[j], ack);
         check(ack == (ok_addr && j < 10), j < 10 ? "R1/R3/R4 ack" : "R4 extra byte no ack",
               32'(ack), 32'(ok_addr && j < 10));
      end
      bus_stop();
      wait_clk(10);
      if (ok_addr) en_model = enable_of(d0, d1);
      check(clk_en_o == en_model, req, 32'(clk_en_o), 32'(en_model));
   endtask

   initial begin
      bit ack;
      void'($urandom(32'h5EED));
      wait_clk(5);
      check(clk_en_o == 13'h1FFF, "R9 reset enables", 32'(clk_en_o), 32'h1FFF);
      check(sda_pull_o == 1'b0, "R9 reset pull", 32'(sda_pull_o), 0);
      rst_n = 1'b1;
      wait_clk(5);

      // R5: a single set bit in bit 0 versus bit 7 of data byte 0
      run_frame(8'hD2, 8'h01, 8'h00, 0, "R5 msb first (01)");
      run_frame(8'hD2, 8'h80, 8'h00, 0, "R5 msb first (80)");
      // R2 / R4: upper bits of data byte 1 have no effect
      run_frame(8'hD2, 8'hA5, 8'hFF, 0, "R2 R4 byte1 mask");
      // R1 / R10: wrong address leaves the enables alone, and trailing bytes go unacked
      run_frame(8'hD3, 8'h00, 8'h00, 0, "R1 R10 wrong address");
      run_frame(8'h52, 8'h00, 8'h00, 1, "R1 wrong address msb");
      // R4: bytes past the tenth are not acknowledged
      run_frame(8'hD2, 8'h3C, 8'h15, 2, "R4 extra bytes");

      // R7 R8: a data byte commits at its ack, then a repeated start restarts the frame
      bus_start();
      send_byte(8'hD2, ack); send_byte(8'h00, ack); send_byte(8'h07, ack);
      send_byte(8'h96, ack);
      wait_clk(10);
      check(clk_en_o[7:0] == 8'h96, "R8 commit after ack", 32'(clk_en_o[7:0]), 32'h96);
      check(clk_en_o[12:8] == en_model[12:8], "R8 byte1 untouched", 32'(clk_en_o[12:8]), 32'(en_model[12:8]));
      en_model[7:0] = 8'h96;
      run_frame(8'hD2, 8'h5A, 8'h03, 0, "R7 repeated start");

      // R8: a frame cut by a stop keeps the data bytes already acknowledged
      bus_start();
      send_byte(8'hD2, ack); send_byte(8'hFF, ack); send_byte(8'hFF, ack);
      send_byte(8'hC3, ack); send_byte(8'h1E, ack);
      bus_stop();
      wait_clk(10);
      en_model = enable_of(8'hC3, 8'h1E);
      check(clk_en_o == en_model, "R8 truncated frame", 32'(clk_en_o), 32'(en_model));

      for (int f = 0; f < 20; f++) begin
         logic [7:0] a;
         a = ($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'hD2;
         run_frame(a, 8'($urandom), 8'($urandom), int'($urandom_range(0, 1)), "R1 R2 random frame");
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule